// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 26-bit physical address by reading two levels of page table from memory. The page number is the upper 20 bits of the address, and it is cut into two 10-bit indices. The upper index selects an entry in the root table. The base frame of the root table is an input. That entry names the frame of a second-level table, and the lower index selects an entry in it. The second-level entry names the physical frame. The 12-bit byte offset is copied through unchanged.

Each table is one 4 KB page holding 1024 entries of 32 bits. A translation therefore needs two dependent memory reads, and the data access that follows it makes a third. The walker handles one request at a time. It has a valid/ready request port, a read port to memory with one read outstanding, and a valid/ready response port. The response carries either the physical address or a page-fault flag.

Top module: `walk2_top`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req are 0.
- R2: In the cycle after a request is accepted, mem_req is 1 for one cycle. mem_addr is then {root frame, vaddr[31:22], 2'b00}.
- R3: If the first-level entry has bit 0 (present) set, mem_req is 1 for one cycle in the cycle after its read data returns. mem_addr is then {entry[25:12], vaddr[21:12], 2'b00}. Entry bits 31:26 and 11:1 are ignored.
- R4: If the second-level entry is present, rsp_valid rises in the cycle after its data returns. rsp_fault is 0 and rsp_paddr is {entry[25:12], vaddr[11:0]}. Entry bits 31:26 and 11:1 are ignored.
- R5: If the first-level entry has bit 0 clear, no second read is issued. rsp_valid rises in the cycle after that data returns, with rsp_fault 1 and rsp_paddr all zero.
- R6: If the second-level entry has bit 0 clear, the response has rsp_fault 1 and rsp_paddr all zero.
- R7: req_ready falls in the cycle after a request is accepted. It stays low until the response handshake and is high again in the following cycle.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R9: mem_req is never high in two successive cycles, and it is issued only at the times given in R2 and R3. A successful walk makes exactly two reads, and a first-level fault makes one.
- R10: root_ppn is sampled when the request is accepted. Changes to root_ppn or req_vaddr after that have no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_ppn | input | 14 | Frame number of the root table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req | output | 1 | One-cycle read strobe for a table entry |
| mem_addr | output | 26 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data valid, one pulse per read |
| mem_rdata | input | 32 | Table entry returned by memory |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 26 | Translated physical address, zero on fault |
| rsp_fault | output | 1 | Page fault at either level |

## Verification
The assertions assume that memory returns exactly one mem_rvalid pulse for each mem_req, no earlier than the cycle after the strobe, and never while no read is outstanding. The bench memory model keeps to this. It arms one pending read for each strobe it sees and answers it after a programmable latency of one to three cycles. The assertions also assume the requester takes the response only while rsp_valid is high. The bench raises rsp_ready only after it has seen the response, or holds it high from the start of a walk.

// File: rtl/walk2_pkg.sv
`timescale 1ns/1ps
package walk2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_ISS  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_ISS  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_st_e;
endpackage

// File: rtl/walk2_rst_sync.sv
`timescale 1ns/1ps
module walk2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/walk2_ctrl.sv
`timescale 1ns/1ps
module walk2_ctrl
  import walk2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic mem_rvalid,
  input  logic ent_present,
  output logic req_ready,
  output logic mem_req,
  output logic rsp_valid,
  output logic use_l2,
  output logic cap_req,
  output logic cap_l1,
  output logic cap_done,
  output logic done_fault
);
  walk_st_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cap_req    = 1'b0;
    cap_l1     = 1'b0;
    cap_done   = 1'b0;
    done_fault = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        cap_req = 1'b1;
        state_d = ST_L1_ISS;
      end
      ST_L1_ISS: state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid) begin
        if (ent_present) begin
          cap_l1  = 1'b1;
          state_d = ST_L2_ISS;
        end else begin
          cap_done   = 1'b1;
          done_fault = 1'b1;
          state_d    = ST_DONE;
        end
      end
      ST_L2_ISS: state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid) begin
        cap_done   = 1'b1;
        done_fault = !ent_present;
        state_d    = ST_DONE;
      end
      ST_DONE: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_L1_ISS) || (state_q == ST_L2_ISS);
  assign use_l2    = (state_q == ST_L2_ISS);
  assign rsp_valid = (state_q == ST_DONE);

  // R9
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);

  // R9
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!req_ready && !rsp_valid));
endmodule

// File: rtl/walk2_path.sv
`timescale 1ns/1ps
module walk2_path #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PA_W  = 26,
  parameter int ENT_W = 32,
  parameter int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [ENT_W-1:0] mem_rdata,
  input  logic             cap_req,
  input  logic             cap_l1,
  input  logic             cap_done,
  input  logic             done_fault,
  input  logic             use_l2,
  input  logic             rsp_valid,
  output logic [PA_W-1:0]  mem_addr,
  output logic             ent_present,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  localparam int ENT_BYTES_LG = OFF_W - IDX_W;
  localparam int HI_IDX_LSB   = VA_W - IDX_W;
  localparam int LO_IDX_LSB   = VA_W - 2 * IDX_W;

  logic [VA_W-1:0]  va_q, va_d;
  logic [PPN_W-1:0] root_q, root_d;
  logic [PPN_W-1:0] tbl_q, tbl_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             flt_q, flt_d;

  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic [PPN_W-1:0] ent_frame;
  logic             unused_ent_bits;

  assign idx_hi      = va_q[HI_IDX_LSB +: IDX_W];
  assign idx_lo      = va_q[LO_IDX_LSB +: IDX_W];
  assign ent_frame   = mem_rdata[OFF_W +: PPN_W];
  assign ent_present = mem_rdata[0];
  assign unused_ent_bits = ^{mem_rdata[ENT_W-1:OFF_W+PPN_W], mem_rdata[OFF_W-1:1]};

  always_comb begin
    va_d   = cap_req  ? req_vaddr : va_q;
    root_d = cap_req  ? root_ppn  : root_q;
    tbl_d  = cap_l1   ? ent_frame : tbl_q;
    pa_d   = pa_q;
    flt_d  = flt_q;
    if (cap_done) begin
      flt_d = done_fault;
      pa_d  = done_fault ? '0 : {ent_frame, va_q[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      pa_q   <= '0;
      flt_q  <= 1'b0;
    end else begin
      va_q   <= va_d;
      root_q <= root_d;
      tbl_q  <= tbl_d;
      pa_q   <= pa_d;
      flt_q  <= flt_d;
    end
  end

  // Table base frame and entry index for the level being read.
  always_comb begin
    if (use_l2) mem_addr = {tbl_q,  idx_lo, {ENT_BYTES_LG{1'b0}}};
    else        mem_addr = {root_q, idx_hi, {ENT_BYTES_LG{1'b0}}};
  end

  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;

  // R5
  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
endmodule

// File: rtl/walk2_top.sv
`timescale 1ns/1ps
module walk2_top #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PA_W  = 26,
  parameter int ENT_W = 32,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  logic rst_sync_n;
  logic use_l2, cap_req, cap_l1, cap_done, done_fault, ent_present;

  walk2_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  walk2_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .rsp_ready   (rsp_ready),
    .mem_rvalid  (mem_rvalid),
    .ent_present (ent_present),
    .req_ready   (req_ready),
    .mem_req     (mem_req),
    .rsp_valid   (rsp_valid),
    .use_l2      (use_l2),
    .cap_req     (cap_req),
    .cap_l1      (cap_l1),
    .cap_done    (cap_done),
    .done_fault  (done_fault)
  );

  walk2_path #(
    .VA_W (VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PA_W (PA_W), .ENT_W(ENT_W), .PPN_W(PPN_W)
  ) u_path (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_vaddr   (req_vaddr),
    .root_ppn    (root_ppn),
    .mem_rdata   (mem_rdata),
    .cap_req     (cap_req),
    .cap_l1      (cap_l1),
    .cap_done    (cap_done),
    .done_fault  (done_fault),
    .use_l2      (use_l2),
    .rsp_valid   (rsp_valid),
    .mem_addr    (mem_addr),
    .ent_present (ent_present),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault)
  );

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

// File: tb/tb_walk2_top.sv
`timescale 1ns/1ps
module tb_walk2_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] root_ppn;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req;
  logic [25:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rsp_valid, rsp_ready;
  logic [25:0] rsp_paddr;
  logic        rsp_fault;

  always #2 clk = ~clk;

  walk2_top dut (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit model_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rd(input logic [25:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction
  function automatic int unsigned ea(input int frame, input int idx);
    return frame * 4096 + idx * 4;
  endfunction

  // Behavioural reference model state
  bit          busy, req_due, rsp_exp, pend, pend_last, hold_chk;
  int          cnt, lat;
  logic [25:0] pend_addr;
  logic [25:0] addr_q[$];
  bit          last_q[$];
  string       tag_q[$];
  logic [25:0] exp_pa, held_pa;
  bit          exp_flt, held_f;
  string       exp_tag;

  task automatic predict(input logic [31:0] va, input logic [13:0] root);
    logic [25:0] a1, a2;
    logic [31:0] e1, e2;
    a1 = {root, va[31:22], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1); last_q.push_back(!e1[0]); tag_q.push_back("R2,R10 first read addr");
    if (e1[0]) begin
      a2 = {e1[25:12], va[21:12], 2'b00};
      e2 = rd(a2);
      addr_q.push_back(a2); last_q.push_back(1'b1); tag_q.push_back("R3 second read addr");
      exp_flt = !e2[0];
      exp_pa  = e2[0] ? {e2[25:12], va[11:0]} : 26'h0;
      exp_tag = e2[0] ? "R4" : "R6";
    end else begin
      exp_flt = 1'b1;
      exp_pa  = 26'h0;
      exp_tag = "R5";
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || !model_on) begin
      mem_rvalid = 1'b0;
      mem_rdata  = 32'h0;
      busy = 0; req_due = 0; rsp_exp = 0; pend = 0; hold_chk = 0;
    end else begin
      chk(req_ready == !busy, "R7 req_ready", {31'h0, req_ready}, {31'h0, !busy});
      chk(mem_req == req_due, "R9 mem_req timing", {31'h0, mem_req}, {31'h0, req_due});
      chk(rsp_valid == rsp_exp, {exp_tag, " rsp_valid timing"}, {31'h0, rsp_valid}, {31'h0, rsp_exp});
      if (hold_chk) begin
        chk(rsp_paddr == held_pa, "R8 paddr hold", {6'h0, rsp_paddr}, {6'h0, held_pa});
        chk(rsp_fault == held_f, "R8 fault hold", {31'h0, rsp_fault}, {31'h0, held_f});
      end
      hold_chk = 0;
      req_due  = 0;
      // memory responder
      mem_rvalid = 1'b0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(pend_addr);
          pend = 0;
          if (pend_last) rsp_exp = 1;
          else           req_due = 1;
        end
      end
      if (mem_req) begin
        if (addr_q.size() == 0) begin
          chk(1'b0, "R9 unexpected read", {6'h0, mem_addr}, 32'h0);
        end else begin
          string t;
          logic [25:0] a;
          a = addr_q.pop_front();
          t = tag_q.pop_front();
          pend_last = last_q.pop_front();
          chk(mem_addr == a, t, {6'h0, mem_addr}, {6'h0, a});
          pend_addr = a;
          pend = 1;
          cnt  = lat;
        end
      end
      // response handshake
      if (rsp_valid && rsp_exp) begin
        if (rsp_ready) begin
          chk(rsp_paddr == exp_pa, {exp_tag, " paddr"}, {6'h0, rsp_paddr}, {6'h0, exp_pa});
          chk(rsp_fault == exp_flt, {exp_tag, " fault"}, {31'h0, rsp_fault}, {31'h0, exp_flt});
          rsp_exp = 0;
          busy    = 0;
        end else begin
          hold_chk = 1;
          held_pa  = rsp_paddr;
          held_f   = rsp_fault;
        end
      end
      // request acceptance
      if (req_valid && req_ready) begin
        busy    = 1;
        req_due = 1;
        predict(req_vaddr, root_ppn);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [13:0] root, input int hold, input int latency);
    @(posedge clk); #1;
    lat       = latency;
    root_ppn  = root;
    req_vaddr = va;
    req_valid = 1'b1;
    rsp_ready = (hold < 0);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    root_ppn  = ~root;          // R10: must not affect the walk
    req_vaddr = ~va;
    do @(negedge clk); while (!rsp_valid);
    if (hold > 0) repeat (hold) @(negedge clk);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_vaddr = 32'h0; root_ppn = 14'h0; lat = 1;
    mem[ea(14'h10, 3)]    = 32'hFC020FF3;
    mem[ea(14'h10, 5)]    = 32'h00030FFE;
    mem[ea(14'h10, 7)]    = 32'h00021001;
    mem[ea(14'h10, 1023)] = 32'h00022001;
    mem[ea(14'h20, 42)]   = 32'h01234001;
    mem[ea(14'h20, 43)]   = 32'h05678000;
    mem[ea(14'h21, 0)]    = 32'h03FFF001;
    mem[ea(14'h22, 1023)] = 32'h00000001;
    mem[ea(14'h3FFF, 0)]  = 32'h00020001;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req", {31'h0, mem_req}, 32'h0);
    model_on = 1;
    walk({10'd3, 10'd42, 12'hABC}, 14'h10, 2, 1);     // R4 success, garbage in entry bits
    walk({10'd5, 10'd42, 12'h555}, 14'h10, 1, 2);     // R5 first-level fault
    walk({10'd3, 10'd43, 12'h123}, 14'h10, 3, 3);     // R6 second-level fault
    walk({10'd7, 10'd0, 12'hFFF}, 14'h10, -1, 1);     // R4 top frame, ready held
    walk({10'd1023, 10'd1023, 12'h000}, 14'h10, 0, 2); // R4 top indices, frame 0
    walk({10'd0, 10'd42, 12'h001}, 14'h3FFF, 1, 1);   // R2 top root frame
    walk({10'd9, 10'd1, 12'h010}, 14'h10, -1, 3);     // R5 missing entry
    repeat (4) @(negedge clk);
    chk(addr_q.size() == 0, "R9 all reads issued", addr_q.size(), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule